// File: doc/BRIEF.md
# SPI Host Queue and Byte Packer

This block is the storage layer between a 32-bit register interface and the byte-wide shift engine of a serial host controller. Software pushes transmit data either as full 32-bit words or as single bytes. The engine drains that data one byte at a time over a valid/ready stream. Bytes received by the engine flow in over a second valid/ready stream. They are packed least-significant byte first into 32-bit words, and software reads them one whole word at a time. A small command queue buffers transfer commands for the engine.

On the engine side the rules for back-pressure are plain. A byte moves only in a cycle where both valid and ready are high. The block holds `tx_byte_valid` and `tx_byte_data` steady until the byte is taken. It lowers `rx_byte_ready` when the packer cannot complete a word because the receive queue is full, or while a flush is waiting. The command stream follows the same handshake. The register side has no back-pressure. A write to a full queue, or a read from an empty one, is dropped and reported with a one-cycle error pulse in the following cycle.

The status outputs are combinational views of the queue state and the programmed watermarks: depths, empty and full flags, watermark comparisons, stall flags, ready and active.

Top module: `sph_datapath`

## Requirements
- R1: A word write (`tx_wr_en`=1, `tx_wr_byte`=0) adds one TX entry. The engine then receives its four bytes in order bits 7:0, 15:8, 23:16, 31:24. While valid is high and ready is low, the byte on the output stays unchanged.
- R2: A byte write (`tx_wr_byte`=1) adds one TX entry that yields exactly one byte, `tx_wr_data[7:0]`. It then moves on to the next entry.
- R3: A TX write while the TX queue holds TX_DEPTH entries is dropped, leaving the depth unchanged. `tx_overflow` is high for the one cycle that follows.
- R4: Received bytes fill a word least-significant byte first. The word enters the RX queue in the edge that accepts its fourth byte.
- R5: A `rx_flush` pulse pushes the partial word one cycle later, with the unfilled upper bytes zero. When no bytes are pending, the flush pushes nothing.
- R6: `rx_rd_data` shows the oldest RX word, and `rx_rd_en` removes it. A read while the queue is empty changes nothing, and `rx_underflow` is high for the following cycle.
- R7: `tx_depth` and `rx_depth` (8 bits) and `cmd_depth` (4 bits) give the entry counts. Each empty flag is high at depth 0, and each full flag is high at the configured depth.
- R8: `rx_wm_flag` = `rx_depth` > RX watermark, and `tx_wm_flag` = `tx_depth` < TX watermark. Both watermarks reset to 0. A watermark write whose value is above its queue depth is ignored.
- R9: `tx_stall` is high when the engine is ready for a byte and the TX queue is empty. `rx_stall` is high when the engine offers a byte that is refused.
- R10: Commands leave in write order on `cmd_valid`/`cmd_data`. `host_ready` is high while the command queue is not full. A command write while the queue is full is dropped, and `cmd_reject` pulses the next cycle. `host_active` = `eng_busy` or the command queue is non-empty.
- R11: `rx_byte_ready` is low when three bytes are pending and the RX queue is full. It is also low in the cycle after a flush request, until that flush is served.
- R12: A word read from the RX queue in the same edge as the packer pushes a word leaves `rx_depth` unchanged, and both words keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Register write into the TX queue |
| tx_wr_byte | input | 1 | 1: byte write, 0: word write |
| tx_wr_data | input | 32 | Write data (byte writes use bits 7:0) |
| tx_overflow | output | 1 | Pulse: TX write dropped |
| tx_byte_valid | output | 1 | TX byte available to the engine |
| tx_byte_ready | input | 1 | Engine takes the TX byte |
| tx_byte_data | output | 8 | TX byte |
| rx_byte_valid | input | 1 | Engine offers a received byte |
| rx_byte_ready | output | 1 | Packer accepts the byte |
| rx_byte_data | input | 8 | Received byte |
| rx_flush | input | 1 | End of receive command: flush partial word |
| rx_rd_en | input | 1 | Register read of one RX word |
| rx_rd_data | output | 32 | Oldest RX word (0 when empty) |
| rx_underflow | output | 1 | Pulse: read of empty RX queue |
| cmd_wr_en | input | 1 | Register write into the command queue |
| cmd_wr_data | input | CMD_W | Command word |
| cmd_reject | output | 1 | Pulse: command write dropped |
| cmd_valid | output | 1 | Command available to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_data | output | CMD_W | Oldest command |
| eng_busy | input | 1 | Engine is executing a command |
| wm_tx_wr | input | 1 | Write TX watermark |
| wm_rx_wr | input | 1 | Write RX watermark |
| wm_data | input | 8 | Watermark value |
| tx_depth | output | 8 | TX entries held |
| rx_depth | output | 8 | RX words held |
| cmd_depth | output | 4 | Commands held |
| tx_empty | output | 1 | TX queue empty |
| tx_full | output | 1 | TX queue full |
| rx_empty | output | 1 | RX queue empty |
| rx_full | output | 1 | RX queue full |
| tx_wm_flag | output | 1 | TX depth below watermark |
| rx_wm_flag | output | 1 | RX depth above watermark |
| tx_stall | output | 1 | Engine starved of TX data |
| rx_stall | output | 1 | Engine blocked by full RX queue |
| host_ready | output | 1 | Another command can be accepted |
| host_active | output | 1 | A command is in progress or queued |

## Verification
Two functions can meet in the RX queue in the same cycle: a software word read, and the packer's push of a completed word. The bench leaves one word in the queue and feeds three bytes. In a single cycle it then offers the fourth byte and raises `rx_rd_en`. It expects the old word on `rx_rd_data`, `rx_depth` still 1 after the edge, and the newly packed word on the next read. A second case covers a stalled fourth byte while the queue is full. The bench checks `rx_stall` and the refused ready, then issues a read. It expects the read to free a slot and the byte to be taken on the cycle after, with the order of the words intact.

// File: rtl/sph_pkg.sv
package sph_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              is_byte;
    logic [WORD_W-1:0] data;
  } tx_ent_t;
endpackage

// File: rtl/sph_fifo.sv
module sph_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (count <= $past(count)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (count == '0));
endmodule

// File: rtl/sph_tx_unpack.sv
module sph_tx_unpack
  import sph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tx_ent_t           head,
  input  logic              head_valid,
  output logic              pop,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data
);
  logic [1:0] idx;
  logic       last;

  assign byte_valid = head_valid;
  assign byte_data  = head.data[{idx, 3'b000} +: BYTE_W];
  assign last       = head.is_byte || (idx == 2'd3);
  assign pop        = byte_valid && byte_ready && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (byte_valid && byte_ready) idx <= last ? 2'd0 : idx + 2'd1;
  end

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));
endmodule

// File: rtl/sph_rx_pack.sv
module sph_rx_pack
  import sph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              flush,
  input  logic              fifo_full,
  output logic              push,
  output logic [WORD_W-1:0] push_data
);
  logic [1:0]  cnt;
  logic [23:0] acc;
  logic        pend, accept, word_push, flush_push, flush_done;

  assign byte_ready = !pend && ((cnt != 2'd3) || !fifo_full);
  assign accept     = byte_valid && byte_ready;
  assign word_push  = accept && (cnt == 2'd3);
  assign flush_push = pend && !fifo_full && (cnt != 2'd0);
  assign flush_done = pend && (!fifo_full || (cnt == 2'd0));
  assign push       = word_push || flush_push;
  assign push_data  = word_push ? {byte_data, acc} : {8'h00, acc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      pend <= 1'b0;
    end else begin
      if (accept) begin
        if (cnt == 2'd3) begin
          cnt <= '0;
          acc <= '0;
        end else begin
          acc[{cnt, 3'b000} +: BYTE_W] <= byte_data;
          cnt <= cnt + 2'd1;
        end
      end
      if (flush_done) begin
        pend <= 1'b0;
        cnt  <= '0;
        acc  <= '0;
      end
      if (flush) pend <= 1'b1;
    end
  end

  // R4
  pack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);
endmodule

// File: rtl/sph_datapath.sv
module sph_datapath
  import sph_pkg::*;
#(
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  parameter int CMD_DEPTH = 4,
  parameter int CMD_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr_en,
  input  logic             tx_wr_byte,
  input  logic [31:0]      tx_wr_data,
  output logic             tx_overflow,
  output logic             tx_byte_valid,
  input  logic             tx_byte_ready,
  output logic [7:0]       tx_byte_data,
  input  logic             rx_byte_valid,
  output logic             rx_byte_ready,
  input  logic [7:0]       rx_byte_data,
  input  logic             rx_flush,
  input  logic             rx_rd_en,
  output logic [31:0]      rx_rd_data,
  output logic             rx_underflow,
  input  logic             cmd_wr_en,
  input  logic [CMD_W-1:0] cmd_wr_data,
  output logic             cmd_reject,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  input  logic             eng_busy,
  input  logic             wm_tx_wr,
  input  logic             wm_rx_wr,
  input  logic [7:0]       wm_data,
  output logic [7:0]       tx_depth,
  output logic [7:0]       rx_depth,
  output logic [3:0]       cmd_depth,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_wm_flag,
  output logic             rx_wm_flag,
  output logic             tx_stall,
  output logic             rx_stall,
  output logic             host_ready,
  output logic             host_active
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int CCW = $clog2(CMD_DEPTH + 1);

  tx_ent_t          tx_in, tx_head;
  logic             tx_pop;
  logic [TCW-1:0]   tx_cnt;
  logic [RCW-1:0]   rx_cnt;
  logic [CCW-1:0]   cmd_cnt;
  logic             rx_push;
  logic [31:0]      rx_push_data, rx_head;
  logic             cmd_full, cmd_empty;
  logic [7:0]       tx_wm, rx_wm;

  assign tx_in = '{is_byte: tx_wr_byte, data: tx_wr_data};

  sph_fifo #(.W($bits(tx_ent_t)), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk, .rst_n, .wr_en(tx_wr_en), .wr_data(tx_in), .rd_en(tx_pop),
    .rd_data(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  sph_tx_unpack u_unpack (
    .clk, .rst_n, .head(tx_head), .head_valid(!tx_empty), .pop(tx_pop),
    .byte_valid(tx_byte_valid), .byte_ready(tx_byte_ready),
    .byte_data(tx_byte_data));

  sph_rx_pack u_pack (
    .clk, .rst_n, .byte_valid(rx_byte_valid), .byte_ready(rx_byte_ready),
    .byte_data(rx_byte_data), .flush(rx_flush), .fifo_full(rx_full),
    .push(rx_push), .push_data(rx_push_data));

  sph_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk, .rst_n, .wr_en(rx_push), .wr_data(rx_push_data), .rd_en(rx_rd_en),
    .rd_data(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  sph_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk, .rst_n, .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
    .rd_en(cmd_ready), .rd_data(cmd_data), .count(cmd_cnt),
    .full(cmd_full), .empty(cmd_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
      cmd_reject   <= 1'b0;
      tx_wm        <= '0;
      rx_wm        <= '0;
    end else begin
      tx_overflow  <= tx_wr_en && tx_full;
      rx_underflow <= rx_rd_en && rx_empty;
      cmd_reject   <= cmd_wr_en && cmd_full;
      if (wm_tx_wr && (wm_data <= 8'(TX_DEPTH))) tx_wm <= wm_data;
      if (wm_rx_wr && (wm_data <= 8'(RX_DEPTH))) rx_wm <= wm_data;
    end
  end

  assign rx_rd_data  = rx_empty ? '0 : rx_head;
  assign tx_depth    = 8'(tx_cnt);
  assign rx_depth    = 8'(rx_cnt);
  assign cmd_depth   = 4'(cmd_cnt);
  assign tx_wm_flag  = tx_depth < tx_wm;
  assign rx_wm_flag  = rx_depth > rx_wm;
  assign tx_stall    = tx_byte_ready && tx_empty;
  assign rx_stall    = rx_byte_valid && !rx_byte_ready;
  assign cmd_valid   = !cmd_empty;
  assign host_ready  = !cmd_full;
  assign host_active = eng_busy || !cmd_empty;

  // R10
  cmd_reject_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> ($past(cmd_cnt) == CCW'(CMD_DEPTH)));
endmodule

// File: tb/sph_datapath_tb.sv
`timescale 1ns/100ps
module sph_datapath_tb;
  logic clk = 0, rst_n = 0;
  logic tx_wr_en = 0, tx_wr_byte = 0; logic [31:0] tx_wr_data = 0;
  logic tx_overflow, tx_byte_valid, tx_byte_ready = 0; logic [7:0] tx_byte_data;
  logic rx_byte_valid = 0, rx_byte_ready, rx_flush = 0, rx_rd_en = 0;
  logic [7:0] rx_byte_data = 0; logic [31:0] rx_rd_data; logic rx_underflow;
  logic cmd_wr_en = 0, cmd_reject, cmd_valid, cmd_ready = 0, eng_busy = 0;
  logic [31:0] cmd_wr_data = 0, cmd_data;
  logic wm_tx_wr = 0, wm_rx_wr = 0; logic [7:0] wm_data = 0;
  logic [7:0] tx_depth, rx_depth; logic [3:0] cmd_depth;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_wm_flag, rx_wm_flag;
  logic tx_stall, rx_stall, host_ready, host_active;

  always #2.5 clk = ~clk;

  sph_datapath u_dut (.*);

  int n_chk = 0, n_fail = 0, cycles = 0, tx_model = 0, cmd_model = 0;
  logic [7:0]  exp_b[$]; bit exp_isb[$];
  logic [31:0] rx_q[$], cmd_q[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for the TX byte stream
  always @(negedge clk) begin
    if (rst_n && tx_byte_valid && tx_byte_ready) begin
      if (exp_b.size() == 0) check(0, "R1 unexpected TX byte", tx_byte_data, 0);
      else begin
        logic [7:0] e; bit isb;
        e = exp_b.pop_front(); isb = exp_isb.pop_front();
        check(tx_byte_data == e, isb ? "R2 TX byte entry" : "R1 TX word byte order",
              tx_byte_data, e);
      end
    end
  end

  task automatic wr_tx(bit isb, logic [31:0] d);
    @(posedge clk); #1 tx_wr_en = 1; tx_wr_byte = isb; tx_wr_data = d;
    if (tx_model < 8) begin
      tx_model++;
      if (isb) begin exp_b.push_back(d[7:0]); exp_isb.push_back(1); end
      else for (int k = 0; k < 4; k++) begin
        exp_b.push_back(d[k*8 +: 8]); exp_isb.push_back(0);
      end
    end
    @(posedge clk); #1 tx_wr_en = 0;
  endtask

  task automatic wr_wm(bit rx, logic [7:0] v);
    @(posedge clk); #1 wm_data = v; wm_tx_wr = !rx; wm_rx_wr = rx;
    @(posedge clk); #1 wm_tx_wr = 0; wm_rx_wr = 0;
  endtask

  task automatic send_rx(logic [7:0] b);
    @(posedge clk); #1 rx_byte_valid = 1; rx_byte_data = b;
    forever begin
      @(negedge clk);
      if (rx_byte_ready) break;
    end
    @(posedge clk); #1 rx_byte_valid = 0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1 rx_flush = 1;
    @(posedge clk); #1 rx_flush = 0;
    @(posedge clk); #1;
  endtask

  task automatic rd_rx(string tag);
    @(posedge clk); #1 rx_rd_en = 1;
    @(negedge clk);
    if (rx_q.size() > 0) begin
      logic [31:0] e; e = rx_q.pop_front();
      check(rx_rd_data == e, tag, rx_rd_data, e);
    end
    @(posedge clk); #1 rx_rd_en = 0;
  endtask

  task automatic wr_cmd(logic [31:0] d);
    @(posedge clk); #1 cmd_wr_en = 1; cmd_wr_data = d;
    if (cmd_model < 4) begin cmd_model++; cmd_q.push_back(d); end
    @(posedge clk); #1 cmd_wr_en = 0;
  endtask

  bit done = 0;
  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check(tx_empty && rx_empty && !tx_full && !rx_full, "R7 reset flags", {tx_empty, rx_empty}, 3);
    check(tx_depth == 0 && rx_depth == 0 && cmd_depth == 0, "R7 reset depths", tx_depth, 0);
    check(!tx_wm_flag && !rx_wm_flag, "R8 reset watermark flags", {tx_wm_flag, rx_wm_flag}, 0);
    check(host_ready && !host_active, "R10 reset ready/active", {host_ready, host_active}, 2);

    // TX fill with mixed writes
    wr_tx(0, 32'h4433_2211);
    wr_tx(1, 32'h1234_56EF);
    check(tx_depth == 2, "R7 TX depth after word+byte", tx_depth, 2);
    check(!tx_stall, "R9 no TX stall when engine idle", tx_stall, 0);
    wr_wm(0, 8'd3);
    check(tx_wm_flag == 1, "R8 TX depth 2 below watermark 3", tx_wm_flag, 1);
    wr_wm(0, 8'd1);
    check(tx_wm_flag == 0, "R8 TX depth 2 not below watermark 1", tx_wm_flag, 0);
    wr_wm(0, 8'd9);
    check(tx_wm_flag == 0, "R8 oversize TX watermark ignored", tx_wm_flag, 0);
    for (int i = 0; i < 6; i++) wr_tx(0, 32'hA0B0C0D0 + i * 32'h0101_0101);
    check(tx_full && tx_depth == 8, "R7 TX full at depth 8", tx_depth, 8);
    wr_tx(1, 32'h0000_0077);
    check(tx_overflow == 1, "R3 overflow pulse on full write", tx_overflow, 1);
    check(tx_depth == 8, "R3 depth unchanged after overflow", tx_depth, 8);
    @(posedge clk); #1;
    check(tx_overflow == 0, "R3 overflow pulse lasts one cycle", tx_overflow, 0);
    // drain through the scoreboard
    tx_byte_ready = 1;
    while (!tx_empty) @(negedge clk);
    @(negedge clk);
    check(tx_stall == 1, "R9 TX stall when starved", tx_stall, 1);
    check(exp_b.size() == 0, "R1 all TX bytes delivered", exp_b.size(), 0);
    @(posedge clk); #1 tx_byte_ready = 0;

    // RX packing
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03); send_rx(8'h04);
    rx_q.push_back(32'h0403_0201);
    check(rx_depth == 1, "R4 word pushed on fourth byte", rx_depth, 1);
    check(rx_wm_flag == 1, "R8 RX depth 1 above watermark 0", rx_wm_flag, 1);
    // R12 same-cycle read and push
    send_rx(8'h10); send_rx(8'h20); send_rx(8'h30);
    @(posedge clk); #1 rx_byte_valid = 1; rx_byte_data = 8'h40; rx_rd_en = 1;
    @(negedge clk);
    check(rx_byte_ready == 1, "R12 fourth byte accepted", rx_byte_ready, 1);
    begin logic [31:0] e; e = rx_q.pop_front();
      check(rx_rd_data == e, "R12 old word read", rx_rd_data, e); end
    @(posedge clk); #1 rx_byte_valid = 0; rx_rd_en = 0;
    rx_q.push_back(32'h4030_2010);
    check(rx_depth == 1, "R12 depth unchanged by read+push", rx_depth, 1);
    rd_rx("R12 new word after same-cycle push");
    // flush
    send_rx(8'hAA); send_rx(8'hBB);
    do_flush();
    rx_q.push_back(32'h0000_BBAA);
    check(rx_depth == 1, "R5 flush pushes partial word", rx_depth, 1);
    rd_rx("R5 partial word zero padded");
    do_flush();
    check(rx_depth == 0, "R5 empty flush pushes nothing", rx_depth, 0);
    rd_rx("R6 empty read");
    check(rx_underflow == 1, "R6 underflow pulse", rx_underflow, 1);
    check(rx_rd_data == 0 && rx_depth == 0, "R6 empty read changes nothing", rx_depth, 0);

    // fill RX, stall
    wr_wm(1, 8'd2);
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 4; k++) send_rx(8'(w * 16 + k));
      rx_q.push_back({8'(w*16+3), 8'(w*16+2), 8'(w*16+1), 8'(w*16)});
    end
    check(rx_full && rx_depth == 8, "R7 RX full at depth 8", rx_depth, 8);
    check(rx_wm_flag == 1, "R8 RX depth 8 above watermark 2", rx_wm_flag, 1);
    send_rx(8'hC1); send_rx(8'hC2); send_rx(8'hC3);
    rx_q.push_back(32'hC4C3_C2C1);
    fork
      send_rx(8'hC4);
      begin
        repeat (3) @(negedge clk);
        check(rx_byte_ready == 0, "R11 ready low with 3 pending and RX full", rx_byte_ready, 0);
        check(rx_stall == 1, "R9 RX stall when blocked", rx_stall, 1);
        rd_rx("R11 read frees slot");
      end
    join
    @(negedge clk);
    check(rx_depth == 8, "R11 stalled byte completed word", rx_depth, 8);
    for (int w = 0; w < 8; w++) rd_rx("R4 RX word order");
    check(rx_empty == 1, "R7 RX empty after drain", rx_empty, 1);

    // commands
    for (int c = 0; c < 5; c++) wr_cmd(32'hC0DE_0000 + c);
    check(cmd_reject == 1, "R10 command write when full rejected", cmd_reject, 1);
    check(cmd_depth == 4 && !host_ready, "R10 command queue full", cmd_depth, 4);
    check(host_active == 1, "R10 active with queued command", host_active, 1);
    @(posedge clk); #1 cmd_ready = 1;
    for (int c = 0; c < 4; c++) begin
      logic [31:0] e;
      @(negedge clk); e = cmd_q.pop_front();
      check(cmd_valid && cmd_data == e, "R10 command order", cmd_data, e);
    end
    @(posedge clk); #1 cmd_ready = 0;
    check(cmd_depth == 0 && host_ready && !host_active, "R10 drained, idle", cmd_depth, 0);
    eng_busy = 1; #1;
    check(host_active == 1, "R10 active while engine busy", host_active, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule